// File: doc/BRIEF.md
# Periodic Clock-Tick Scheduler

This block lets a pipeline run at a fraction of a fast master clock without a divider or a frequency synthesizer. It generates a synchronous clock-enable that is high on one master cycle out of every N. Downstream registers gate their updates with this enable, so they advance at an effective rate of 1/N. A 4-bit rate code selects N from 1 to 16.

Each rate is paired with one of two supply levels. A programmable threshold on the divide ratio decides which rates may run at the low supply. The block orders its two outputs so that the logic is never clocked fast while the low supply is requested. When it speeds up, it raises the supply request one full period before the faster schedule starts. When it slows down, it drops the supply request only after the slower schedule is already running.

Rate changes are taken only at period boundaries. This means no period is ever shortened, merged or split.

Top module: `tick_sched`

## Requirements
- R1: With rate code k active, `tick_en` is high on exactly one cycle of each (k+1)-cycle period. That cycle is the first cycle of the period, and the cycle after the last cycle of a period always carries the tick.
- R2: All 16 codes are supported, mapped as divide ratio = code + 1. Code 0 gives a tick on every cycle and code 15 gives one tick every 16 cycles.
- R3: `rate_code` is sampled only in the last cycle of a period. Values present on any other cycle have no effect on `tick_en` or `vsel_hi`.
- R4: A rate counts as slow when code + 1 >= `thr_div`. With `thr_div` = 9, code 8 is slow and code 7 is fast.
- R5: Suppose a fast code is sampled at a period end while `vsel_hi` is low. Then `vsel_hi` goes high in the next cycle and the old period runs once more. The fast rate starts at the following period end, provided a fast code is still presented there.
- R6: A slow code sampled at a period end takes effect at once, and `vsel_hi` is left unchanged. `vsel_hi` falls only at the end of a period that already ran at a slow rate, and only when the code sampled there is also slow.
- R7: While `rst_n` is low, and after its release until the first rate change, `tick_en` is high on every cycle and `vsel_hi` is high.
- R8: With `thr_div` held stable, `vsel_hi` is low only while a slow rate is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_code | input | 4 | Requested divide ratio minus one |
| thr_div | input | 5 | Smallest divide ratio allowed at the low supply; hold stable while running |
| tick_en | output | 1 | Clock-enable for downstream registers |
| vsel_hi | output | 1 | 1 requests the high supply, 0 the low supply |

## Verification
A corrupted period counter or an adopted rate at the wrong moment shows up at `tick_en` as a gap that is too short or too long. This becomes visible at the next expected tick, at most 16 cycles later. A wrong supply state shows up as `vsel_hi` moving in a cycle that does not follow a period end, or staying low while ticks arrive closer together than the threshold allows. The second case is visible within one period of the faulty change. The bench compares both outputs cycle by cycle against a model of the requirements, across code changes that land mid-period and across changes on both sides of the threshold.

// File: rtl/tick_sched_pkg.sv
package tick_sched_pkg;

  localparam int RATE_W_DEF = 4;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } supply_lvl_e;

endpackage

// File: rtl/ts_period_ctr.sv
module ts_period_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_k,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         tick_en
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign wrap    = (cnt_q == period_k);
  assign tick_en = (cnt_q == '0);
  assign cnt     = cnt_q;

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ts_slow_cmp.sv
module ts_slow_cmp #(
  parameter int W = 4,
  localparam int TW = W + 1
) (
  input  logic [W-1:0]  code,
  input  logic [TW-1:0] thr,
  output logic          is_slow
);

  logic [TW-1:0] ratio;

  assign ratio   = TW'(code) + TW'(1);
  assign is_slow = (ratio >= thr);

endmodule

// File: rtl/ts_rate_ctl.sv
module ts_rate_ctl
  import tick_sched_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] req_code,
  input  logic         req_slow,
  input  logic         cur_slow,
  output logic [W-1:0] cur_k,
  output logic         vsel_hi
);

  logic [W-1:0] k_q, k_d;
  supply_lvl_e  lvl_q, lvl_d;
  logic         upd_en;

  assign upd_en = wrap;

  always_comb begin
    k_d   = k_q;
    lvl_d = lvl_q;
    if (!req_slow) begin
      if (lvl_q == LVL_HIGH) k_d = req_code;
      else                   lvl_d = LVL_HIGH;
    end else begin
      k_d = req_code;
      if (cur_slow) lvl_d = LVL_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      lvl_q <= LVL_HIGH;
    end else if (upd_en) begin
      k_q   <= k_d;
      lvl_q <= lvl_d;
    end
  end

  assign cur_k   = k_q;
  assign vsel_hi = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/tick_sched.sv
module tick_sched
  import tick_sched_pkg::*;
#(
  parameter int RATE_W = RATE_W_DEF,
  localparam int THR_W = RATE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [THR_W-1:0]  thr_div,
  output logic              tick_en,
  output logic              vsel_hi
);

  logic [RATE_W-1:0] cur_k_w;
  logic [RATE_W-1:0] cnt_w;
  logic              wrap_w;
  logic              req_slow_w;
  logic              cur_slow_w;

  ts_period_ctr #(.W(RATE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_k (cur_k_w),
    .cnt      (cnt_w),
    .wrap     (wrap_w),
    .tick_en  (tick_en)
  );

  ts_slow_cmp #(.W(RATE_W)) u_cmp_req (
    .code    (rate_code),
    .thr     (thr_div),
    .is_slow (req_slow_w)
  );

  ts_slow_cmp #(.W(RATE_W)) u_cmp_cur (
    .code    (cur_k_w),
    .thr     (thr_div),
    .is_slow (cur_slow_w)
  );

  ts_rate_ctl #(.W(RATE_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap_w),
    .req_code (rate_code),
    .req_slow (req_slow_w),
    .cur_slow (cur_slow_w),
    .cur_k    (cur_k_w),
    .vsel_hi  (vsel_hi)
  );

endmodule

// File: rtl/tick_sched_checker.sv
module tick_sched_checker #(
  parameter int W = 4,
  localparam int TW = W + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          vsel_hi,
  input logic [TW-1:0] thr_div,
  input logic [W-1:0]  cur_k,
  input logic [W-1:0]  cnt
);

  AST_ONE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cur_k != '0) |=> !tick_en); // R1

  AST_TICK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cur_k) |=> tick_en); // R1

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_k); // R2

  AST_RATE_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != cur_k) |=> $stable(cur_k)); // R3

  AST_SUPPLY_HELD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != cur_k) |=> $stable(vsel_hi)); // R5

  AST_LOW_ONLY_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsel_hi && $stable(thr_div)) |-> ((TW'(cur_k) + TW'(1)) >= thr_div)); // R8

endmodule

bind tick_sched tick_sched_checker #(.W(RATE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .vsel_hi (vsel_hi),
  .thr_div (thr_div),
  .cur_k   (cur_k_w),
  .cnt     (cnt_w)
);

// File: tb/tick_sched_test.sv
module tick_sched_test;

  logic       clk;
  logic       rst_n;
  logic [3:0] rate_code;
  logic [4:0] thr_div;
  logic       tick_en;
  logic       vsel_hi;

  int n_checks;
  int n_errors;
  bit done;

  typedef struct {
    bit    tick;
    bit    vhi;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // reference state, written from the requirements
  int m_cnt, m_k;
  bit m_v;
  int THR;

  tick_sched uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_code (rate_code),
    .thr_div   (thr_div),
    .tick_en   (tick_en),
    .vsel_hi   (vsel_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit slow_of(int code);
    return (code + 1) >= THR;
  endfunction

  task automatic model_reset();
    m_cnt = 0;
    m_k   = 0;
    m_v   = 1'b1;
  endtask

  task automatic model_step(int code);
    if (m_cnt == m_k) begin
      if (!slow_of(code)) begin
        if (m_v) m_k = code;
        else     m_v = 1'b1;
      end else begin
        if (slow_of(m_k)) m_v = 1'b0;
        m_k = code;
      end
      m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
    end
  endtask

  task automatic push_exp(string tag);
    exp_t e;
    e.tick = (m_cnt == 0);
    e.vhi  = m_v;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic hold_reset(int n);
    repeat (n) begin
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      push_exp("R7");
    end
  endtask

  task automatic run(int code, int n, string tag);
    repeat (n) begin
      @(negedge clk);
      rst_n     = 1'b1;
      rate_code = 4'(code);
      push_exp(tag);
      model_step(code);
    end
  endtask

  // monitor: pops one expectation per cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (tick_en !== e.tick) begin
          n_errors++;
          $display("FAIL %s tick_en actual=%0b expected=%0b t=%0t", e.tag, tick_en, e.tick, $time);
        end
        n_checks++;
        if (vsel_hi !== e.vhi) begin
          n_errors++;
          $display("FAIL %s vsel_hi actual=%0b expected=%0b t=%0t", e.tag, vsel_hi, e.vhi, $time);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    done      = 1'b0;
    THR       = 9;
    thr_div   = 5'd9;
    rate_code = 4'd0;
    rst_n     = 1'b0;
    model_reset();

    hold_reset(3);            // R7 reset state
    run(0, 6, "R7");          // divide by 1 after release
    run(3, 24, "R1");         // divide by 4
    run(2, 15, "R1");         // divide by 3
    run(15, 40, "R2");        // longest period, slow, supply drops after one period (R6)
    run(8, 30, "R4");         // ratio 9 is exactly at threshold: slow
    run(1, 20, "R5");         // speed-up: supply first, rate one period later
    run(7, 24, "R4");         // ratio 8 just below threshold: fast
    run(12, 3, "R6");         // slow code, taken at next end, supply held
    run(12, 40, "R6");
    run(10, 30, "R8");
    for (int i = 0; i < 90; i++) begin
      run((i * 7 + 3) % 16, 1, "R3"); // codes move every cycle; only end-of-period values count
    end
    run(0, 10, "R5");
    hold_reset(2);            // mid-run reset
    run(0, 4, "R7");
    run(5, 20, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule